// File: doc/BRIEF.md
# Eight-Operation Four-Bit ALU

A purely combinational arithmetic-logic unit. It takes two operands, `a_i` and `b_i`, and a 3-bit operation code `op_i`, and produces a result `z_o`. The operands are 4-bit two's complement by default. The top opcode bit chooses between two halves.

The arithmetic half is one shared ripple chain of full adders. A small conditioning stage in front of each adder bit rewrites the operand bits according to the two low opcode bits. The carry into bit 0 comes from the opcode alone. With these, one chain computes A−1, B−A, A+B and B+1.

The logical half is a per-bit function generator. It computes NAND, NOR, XOR or AND. The block also reports the carry out of the top adder bit and a signed overflow flag. Both flags are forced low for logical operations.

Top module: `alu8_top`

## Requirements
- R1: Opcode 3'b000 gives z_o = (A − 1) mod 16.
- R2: Opcode 3'b001 gives z_o = (B − A) mod 16.
- R3: Opcode 3'b010 gives z_o = (A + B) mod 16.
- R4: Opcode 3'b011 gives z_o = (B + 1) mod 16.
- R5: Opcode 3'b100 gives z_o = bitwise NOT (A AND B).
- R6: Opcode 3'b101 gives z_o = bitwise NOT (A OR B).
- R7: Opcode 3'b110 gives z_o = A XOR B.
- R8: Opcode 3'b111 gives z_o = A AND B.
- R9: For arithmetic opcodes, carry_o is the unsigned carry out of the top adder bit, as follows:
  - For A−1, it is 1 exactly when A ≠ 0.
  - For B−A, it is 1 exactly when B ≥ A unsigned.
  - For A+B, it is 1 exactly when A+B > 15.
  - For B+1, it is 1 exactly when B = 15.
- R10: For arithmetic opcodes, ovf_o is 1 exactly when the signed result of the operation lies outside the range −8..7.
- R11: When op_i[2] is 1, carry_o and ovf_o are both 0.
- R12: The block holds no state. Outputs follow a change of inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A, two's complement |
| b_i | input | 4 | Operand B, two's complement |
| op_i | input | 3 | Operation code; bit 2 selects the logical half |
| z_o | output | 4 | Result |
| carry_o | output | 1 | Carry out of the top adder bit (arithmetic only) |
| ovf_o | output | 1 | Signed overflow (arithmetic only) |

## Verification
The bench targets the places where a shared adder is easy to get wrong, each by a directed vector:
- A−1 at A=0 and A=8. A forced all-ones operand or a wrong carry-in would shift the result by one or clear the borrow carry.
- B−A at equal operands and at the −8−1 wrap. An inversion of the wrong operand gives A−B, and a missing carry-in is off by one.
- B+1 at B=7 and B=15. An overflow flag taken from the wrong carry pair would miss the sign flip.
- Logical opcodes, checked for stale carry or overflow leaking out.

An exhaustive sweep of all 2048 input combinations then catches any swapped entry in the opcode map.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [1:0] {
    ARITH_A_DEC = 2'b00,
    ARITH_B_SUB = 2'b01,
    ARITH_ADD   = 2'b10,
    ARITH_B_INC = 2'b11
  } arith_sel_e;

  typedef enum logic [1:0] {
    LOGIC_NAND = 2'b00,
    LOGIC_NOR  = 2'b01,
    LOGIC_XOR  = 2'b10,
    LOGIC_AND  = 2'b11
  } logic_sel_e;
endpackage

// File: rtl/alu8_operand_cond.sv
module alu8_operand_cond
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  arith_sel_e       sel_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o,
  output logic             cin_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        ARITH_A_DEC: begin x_o[i] = a_i[i];  y_o[i] = 1'b1;   end
        ARITH_B_SUB: begin x_o[i] = ~a_i[i]; y_o[i] = b_i[i]; end
        ARITH_ADD:   begin x_o[i] = a_i[i];  y_o[i] = b_i[i]; end
        default:     begin x_o[i] = 1'b0;    y_o[i] = b_i[i]; end
      endcase
    end
  end

  // carry-in is set for the two "+1" style ops (B-A, B+1)
  assign cin_o = sel_i[0];
endmodule

// File: rtl/alu8_ripple_adder.sv
module alu8_ripple_adder #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH:0]   carry_o
);
  assign carry_o[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic half_s;
    assign half_s       = x_i[i] ^ y_i[i];
    assign sum_o[i]     = half_s ^ carry_o[i];
    assign carry_o[i+1] = (x_i[i] & y_i[i]) | (half_s & carry_o[i]);
  end
endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic_sel_e       sel_i,
  output logic [WIDTH-1:0] res_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LOGIC_NAND: res_o[i] = ~(a_i[i] & b_i[i]);
        LOGIC_NOR:  res_o[i] = ~(a_i[i] | b_i[i]);
        LOGIC_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        default:    res_o[i] = a_i[i] & b_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alu8_top.sv
module alu8_top
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] z_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] x_s, y_s, sum_s, logic_s;
  logic [WIDTH:0]   chain_s;
  logic             cin_s;
  logic             is_logic_s;
  arith_sel_e       arith_sel_s;
  logic_sel_e       logic_sel_s;

  assign is_logic_s  = op_i[2];
  assign arith_sel_s = arith_sel_e'(op_i[1:0]);
  assign logic_sel_s = logic_sel_e'(op_i[1:0]);

  alu8_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (arith_sel_s),
    .x_o   (x_s),
    .y_o   (y_s),
    .cin_o (cin_s)
  );

  alu8_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i     (x_s),
    .y_i     (y_s),
    .cin_i   (cin_s),
    .sum_o   (sum_s),
    .carry_o (chain_s)
  );

  alu8_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (logic_sel_s),
    .res_o (logic_s)
  );

  assign z_o     = is_logic_s ? logic_s : sum_s;
  assign carry_o = ~is_logic_s & chain_s[WIDTH];
  assign ovf_o   = ~is_logic_s & (chain_s[WIDTH] ^ chain_s[MSB]);
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] z_o,
  input logic             carry_o,
  input logic             ovf_o
);
  logic [WIDTH-1:0] one_s;
  assign one_s = WIDTH'(1);

  always_comb begin
    if (op_i == 3'b000) AST_A_DEC: assert (z_o == a_i - one_s);           // R1
    if (op_i == 3'b001) AST_B_SUB: assert (z_o == b_i - a_i);             // R2
    if (op_i == 3'b010) AST_ADD: assert ({carry_o, z_o} == {1'b0, a_i} + {1'b0, b_i}); // R3
    if (op_i == 3'b011) AST_B_INC: assert (z_o == b_i + one_s);           // R4
    if (op_i == 3'b111) AST_AND: assert (z_o == (a_i & b_i));             // R8
    if (op_i == 3'b110) AST_XOR: assert (z_o == (a_i ^ b_i));             // R7
    if (op_i == 3'b010) AST_ADD_OVF: assert (ovf_o ==
        ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (z_o[WIDTH-1] != a_i[WIDTH-1]))); // R10
    if (op_i == 3'b011) AST_INC_CARRY: assert (carry_o == (&b_i));        // R9
    if (op_i[2]) AST_NO_LOGIC_FLAGS: assert (!carry_o && !ovf_o);         // R11
  end
endmodule

bind alu8_top alu8_checker #(.WIDTH(WIDTH)) u_alu8_checker (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .z_o     (z_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/tb_alu8_top.sv
`timescale 1ns/1ps
module tb_alu8_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] a, b, z;
  logic [2:0] op;
  logic       c, v;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu8_top dut (
    .a_i(a), .b_i(b), .op_i(op), .z_o(z), .carry_o(c), .ovf_o(v)
  );

  // {op, a, b, z, carry, ovf}
  localparam logic [16:0] VEC [13] = '{
    {3'b000, 4'h0, 4'h0, 4'hF, 1'b0, 1'b0},  // R1 A=0
    {3'b000, 4'h8, 4'h0, 4'h7, 1'b1, 1'b1},  // R1 -8-1
    {3'b001, 4'h3, 4'h3, 4'h0, 1'b1, 1'b0},  // R2 equal
    {3'b001, 4'h1, 4'h0, 4'hF, 1'b0, 1'b0},  // R2 borrow
    {3'b001, 4'h1, 4'h8, 4'h7, 1'b1, 1'b1},  // R2 wrap
    {3'b010, 4'h7, 4'h1, 4'h8, 1'b0, 1'b1},  // R3 pos ovf
    {3'b010, 4'hF, 4'h1, 4'h0, 1'b1, 1'b0},  // R3 carry
    {3'b011, 4'h0, 4'hF, 4'h0, 1'b1, 1'b0},  // R4 B=15
    {3'b011, 4'h5, 4'h7, 4'h8, 1'b0, 1'b1},  // R4 B=7
    {3'b100, 4'hC, 4'hA, 4'h7, 1'b0, 1'b0},  // R5
    {3'b101, 4'hC, 4'hA, 4'h1, 1'b0, 1'b0},  // R6
    {3'b110, 4'hC, 4'hA, 4'h6, 1'b0, 1'b0},  // R7
    {3'b111, 4'hC, 4'hA, 4'h8, 1'b0, 1'b0}   // R8
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s op=%b a=%h b=%h {z,c,v} actual=%h expected=%h", req, op, a, b, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_model(input logic [2:0] o, input logic [3:0] ra, input logic [3:0] rb);
    int sa, sb, res, ures;
    logic cr;
    sa = $signed(ra); sb = $signed(rb);
    cr = 1'b0;
    case (o)
      3'b000: begin res = sa - 1;  ures = 0; cr = (ra != 0); end
      3'b001: begin res = sb - sa; ures = 0; cr = (rb >= ra); end
      3'b010: begin res = sa + sb; ures = int'(ra) + int'(rb); cr = (ures > 15); end
      3'b011: begin res = sb + 1;  ures = 0; cr = (rb == 4'hF); end
      3'b100: return {~(ra & rb), 2'b00};
      3'b101: return {~(ra | rb), 2'b00};
      3'b110: return {ra ^ rb, 2'b00};
      default: return {ra & rb, 2'b00};
    endcase
    return {res[3:0], cr, (res > 7 || res < -8)};
  endfunction

  initial begin
    {op, a, b} = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 at time of release: all-zero inputs give A-1 = F, no overflow
    check("R1", {z, c, v}, 6'b1111_0_0);

    for (int i = 0; i < 13; i++) begin
      {op, a, b} = VEC[i][16:6];
      @(negedge clk);
      check($sformatf("R1-R11 vec%0d", i), {z, c, v}, VEC[i][5:0]);
    end

    // R12: no clock edge between input change and sample
    {op, a, b} = {3'b010, 4'h2, 4'h3};
    #1 check("R12", {z, c, v}, 6'b0101_0_0);
    {op, a, b} = {3'b110, 4'h2, 4'h3};
    #1 check("R12", {z, c, v}, 6'b0001_0_0);

    // exhaustive sweep: R1..R11
    for (int k = 0; k < 2048; k++) begin
      {op, a, b} = k[10:0];
      @(negedge clk);
      check("R9 R10 R11 sweep", {z, c, v}, ref_model(op, a, b));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule